// File: doc/BRIEF.md
# I2C Byte-Store Target Engine

This block is the bus-facing half of a 256-byte serial memory. It watches a two-wire bus through oversampled clock and data inputs, runs on a fast system clock, and recognises START, repeated START and STOP conditions. After a START it compares the incoming device byte against a fixed four-bit prefix (1010) and three strap pins. It then accepts a byte address and data bytes for writes, or streams stored bytes back for reads. It pulls the data line low through an open-drain enable to acknowledge, and to send the zero bits of read data.

Writes are not stored here. Each received data byte leaves as a one-cycle request with its address, and every STOP leaves as a one-cycle event, both aimed at a separate page buffer. Reads take data from the store combinationally through an address output that shows the internal byte counter. A busy input, raised by the page buffer while it commits, makes the engine refuse its own device address, so a master can poll until the store is ready.

Top module: `i2c_mem_target`

## Requirements
- R1: A START (data falling while clock high) restarts device-address reception from any state. A STOP (data rising while clock high) returns the engine to idle and pulses `stop_evt_o` for exactly one cycle. Either condition releases `sda_oe_o`.
- R2: The device byte is matched MSB first as 1010, then `strap_i[2:1:0]`, then the direction bit (1 = read, 0 = write). On a match the engine holds `sda_oe_o` high (line pulled low) through the ninth clock.
- R3: In a write transfer, the byte address and every data byte are acknowledged on their ninth clock.
- R4: Each received write data byte produces exactly one single-cycle `wr_req_o`, carrying `wr_addr_o` equal to the counter and `wr_data_o` equal to the byte. The counter then advances within its 16-byte page: the low four bits wrap and the high four bits are held.
- R5: A read sends the byte at the counter MSB first. `sda_oe_o` is the inverse of each bit and changes only while the clock is low. A master ACK on the ninth clock fetches the next byte. A NACK ends the read.
- R6: After a read the counter points one past the last byte sent and wraps from 255 to 0. It persists across transactions, so a current-address read continues from it.
- R7: A write-direction device byte plus one byte address, followed by a repeated START and a read-direction device byte, reads from the loaded address.
- R8: While `busy_i` is high when the device byte completes, that byte is not acknowledged.
- R9: After a device byte that does not match, the engine gives no acknowledge, issues no write request and leaves the counter unchanged until the next START.
- R10: After reset `sda_oe_o`, `wr_req_o` and `stop_evt_o` are low and `rd_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level (wired-AND of all drivers) |
| strap_i | input | 3 | Device select strap pins |
| busy_i | input | 1 | Store busy committing; suppresses device-address ACK |
| rd_data_i | input | 8 | Store data at `rd_addr_o` |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| rd_addr_o | output | 8 | Current byte counter, read address to the store |
| wr_req_o | output | 1 | One-cycle byte write request |
| wr_addr_o | output | 8 | Address of the write request |
| wr_data_o | output | 8 | Data of the write request |
| stop_evt_o | output | 1 | One-cycle pulse on every STOP |

## Verification
The properties assume a well-behaved master. Data changes only while the clock is low, except for START and STOP. Each clock phase lasts many system cycles longer than the synchronizer delay, so a drive change made after a falling edge is seen while the clock is still low. The stimulus keeps both half periods at 20 system cycles and waits two cycles after every clock fall before moving data. The busy input changes only between transactions.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADR,
    ST_WR,
    ST_RD
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_lvl   = scl_s;
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          PAGE_W     = 4,
  parameter logic [3:0]  DEV_PREFIX = 4'b1010,
  parameter int          CNT_W      = $clog2(BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_lvl,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              stop_evt_o,
  output tgt_state_e        state_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  tgt_state_e        state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] shreg, shreg_n;
  logic [BYTE_W-1:0] txreg, txreg_n;
  logic [ADDR_W-1:0] ptr, ptr_n;
  logic              rw, rw_n;
  logic              mack, mack_n;
  logic              oe, oe_n;
  logic              wreq, wreq_n;
  logic [ADDR_W-1:0] waddr, waddr_n;
  logic [BYTE_W-1:0] wdata, wdata_n;
  logic              sevt, sevt_n;
  logic              dev_hit;
  logic [ADDR_W-1:0] ptr_page_inc;

  assign dev_hit      = (shreg[BYTE_W-1:1] == {DEV_PREFIX, strap_i}) && !busy_i;
  assign ptr_page_inc = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    shreg_n = shreg;
    txreg_n = txreg;
    ptr_n   = ptr;
    rw_n    = rw;
    mack_n  = mack;
    oe_n    = oe;
    waddr_n = waddr;
    wdata_n = wdata;
    wreq_n  = 1'b0;
    sevt_n  = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      oe_n    = 1'b0;
      sevt_n  = 1'b1;
    end else if (start_det) begin
      state_n = ST_DEV;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise && cnt != ACK_BIT) begin
        cnt_n = cnt + 1'b1;
        if (state == ST_RD) begin
          if (cnt == LAST_BIT) mack_n = ~sda_lvl;
        end else if (cnt < LAST_BIT) begin
          shreg_n = {shreg[BYTE_W-2:0], sda_lvl};
        end
      end else if (scl_fall) begin
        if (state == ST_RD) begin
          if (cnt != '0 && cnt < LAST_BIT) begin
            oe_n    = ~txreg[BYTE_W-1];
            txreg_n = {txreg[BYTE_W-2:0], 1'b0};
          end else if (cnt == LAST_BIT) begin
            oe_n = 1'b0;
          end else if (cnt == ACK_BIT) begin
            cnt_n = '0;
            if (mack) begin
              oe_n    = ~rd_data_i[BYTE_W-1];
              txreg_n = {rd_data_i[BYTE_W-2:0], 1'b0};
              ptr_n   = ptr + 1'b1;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_IDLE;
            end
          end
        end else if (cnt == LAST_BIT) begin
          case (state)
            ST_DEV: begin
              if (dev_hit) begin
                oe_n = 1'b1;
                rw_n = shreg[0];
              end else begin
                state_n = ST_IDLE;
                cnt_n   = '0;
              end
            end
            ST_ADR: begin
              oe_n  = 1'b1;
              ptr_n = shreg[ADDR_W-1:0];
            end
            ST_WR: begin
              oe_n    = 1'b1;
              wreq_n  = 1'b1;
              waddr_n = ptr;
              wdata_n = shreg;
              ptr_n   = ptr_page_inc;
            end
            default: ;
          endcase
        end else if (cnt == ACK_BIT) begin
          oe_n  = 1'b0;
          cnt_n = '0;
          case (state)
            ST_DEV: begin
              if (rw) begin
                state_n = ST_RD;
                oe_n    = ~rd_data_i[BYTE_W-1];
                txreg_n = {rd_data_i[BYTE_W-2:0], 1'b0};
                ptr_n   = ptr + 1'b1;
              end else begin
                state_n = ST_ADR;
              end
            end
            ST_ADR:  state_n = ST_WR;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
      txreg <= '0;
      ptr   <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      oe    <= 1'b0;
      wreq  <= 1'b0;
      waddr <= '0;
      wdata <= '0;
      sevt  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      shreg <= shreg_n;
      txreg <= txreg_n;
      ptr   <= ptr_n;
      rw    <= rw_n;
      mack  <= mack_n;
      oe    <= oe_n;
      wreq  <= wreq_n;
      sevt  <= sevt_n;
      if (wreq_n) begin
        waddr <= waddr_n;
        wdata <= wdata_n;
      end
    end
  end

  assign sda_oe_o   = oe;
  assign ptr_o      = ptr;
  assign wr_req_o   = wreq;
  assign wr_addr_o  = waddr;
  assign wr_data_o  = wdata;
  assign stop_evt_o = sevt;
  assign state_o    = state;
  assign cnt_o      = cnt;
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              stop_evt_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);

  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [1:0]       line_sync;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e       ctl_state;
  logic [CNT_W-1:0] ctl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .raw_i  ({scl_i, sda_i}),
    .sync_o (line_sync)
  );

  i2c_cond_detect u_cond (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_s     (line_sync[1]),
    .sda_s     (line_sync[0]),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ctrl #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .DEV_PREFIX (DEV_PREFIX),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_lvl    (sda_lvl),
    .strap_i    (strap_i),
    .busy_i     (busy_i),
    .rd_data_i  (rd_data_i),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (rd_addr_o),
    .wr_req_o   (wr_req_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .stop_evt_o (stop_evt_o),
    .state_o    (ctl_state),
    .cnt_o      (ctl_cnt)
  );
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              busy_i,
  input logic              sda_oe,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              stop_evt,
  input tgt_state_e        ctl_state,
  input logic [CNT_W-1:0]  ctl_cnt
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  assert_stop_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !stop_evt);

  assert_release_on_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (rd_addr[ADDR_W-1:PAGE_W] == wr_addr[ADDR_W-1:PAGE_W]) &&
               (rd_addr[PAGE_W-1:0] == PAGE_W'(wr_addr[PAGE_W-1:0] + 1'b1)));

  assert_drive_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  assert_busy_noack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == ST_DEV && ctl_cnt == LAST_BIT && scl_fall && busy_i) |=> !sda_oe);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_state == ST_IDLE) |-> (!sda_oe && !wr_req));
endmodule

bind i2c_mem_target i2c_mem_target_chk #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .scl_lvl   (scl_lvl),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .busy_i    (busy_i),
  .sda_oe    (sda_oe_o),
  .wr_req    (wr_req_o),
  .wr_addr   (wr_addr_o),
  .rd_addr   (rd_addr_o),
  .stop_evt  (stop_evt_o),
  .ctl_state (ctl_state),
  .ctl_cnt   (ctl_cnt)
);

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
  localparam int H = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic sda_oe, wr_req, stop_evt;
  logic [7:0] rd_addr, wr_addr, wr_data, rd_data;
  logic sda_bus;

  logic [7:0] store [256];
  logic [7:0] model_mem [256];
  logic [7:0] model_ptr;
  logic [15:0] exp_q [$];
  int n_checks = 0;
  int n_err = 0;
  int stops_seen = 0;
  int stops_exp = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = store[rd_addr];

  i2c_mem_target i_i2c_mem_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .strap_i    (STRAP),
    .busy_i     (busy),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe),
    .rd_addr_o  (rd_addr),
    .wr_req_o   (wr_req),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .stop_evt_o (stop_evt)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison of write requests against the model queue
  always @(negedge clk) begin
    if (rst_n && wr_req) begin
      if (exp_q.size() == 0) begin
        check("R4/R9 unexpected write request", {wr_addr, wr_data}, 0);
      end else begin
        check("R4 write request addr/data", {wr_addr, wr_data}, exp_q.pop_front());
      end
      store[wr_addr] = wr_data;
    end
    if (rst_n && stop_evt) stops_seen++;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b0; wait_n(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
    stops_exp++;
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_n(H);
      scl_m = 1'b1; wait_n(H);
      scl_m = 1'b0; wait_n(2);
    end
    sda_m = 1'b1; wait_n(H);
    scl_m = 1'b1; wait_n(H / 2);
    acked = (sda_bus == 1'b0);
    wait_n(H / 2);
    scl_m = 1'b0; wait_n(2);
  endtask

  task automatic rx_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(H);
      scl_m = 1'b1; wait_n(H / 2);
      b[i] = sda_bus;
      wait_n(H / 2);
      scl_m = 1'b0; wait_n(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    scl_m = 1'b0; wait_n(2);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] seed);
    bit ack;
    logic [7:0] d;
    bus_start();
    tx_byte(DEV_W, ack); check("R2 device ACK (write)", ack, 1);
    tx_byte(a, ack);     check("R3 byte address ACK", ack, 1);
    model_ptr = a;
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 17);
      exp_q.push_back({model_ptr, d});
      model_mem[model_ptr] = d;
      tx_byte(d, ack); check("R3 data byte ACK", ack, 1);
      model_ptr = {model_ptr[7:4], model_ptr[3:0] + 4'd1};
    end
    bus_stop();
    wait_n(4);
    check("R4 all write requests issued", exp_q.size(), 0);
    check("R4 counter after page write", rd_addr, model_ptr);
  endtask

  task automatic do_read(input bit random, input logic [7:0] a, input int n);
    bit ack;
    logic [7:0] d;
    bus_start();
    if (random) begin
      tx_byte(DEV_W, ack); check("R7 dummy-write device ACK", ack, 1);
      tx_byte(a, ack);     check("R7 read address ACK", ack, 1);
      model_ptr = a;
      bus_start();
    end
    tx_byte(DEV_R, ack); check("R2 device ACK (read)", ack, 1);
    for (int i = 0; i < n; i++) begin
      rx_byte(i < n - 1, d);
      check(random ? "R7 R5 random/sequential read data" : "R6 current-address read data",
            d, model_mem[model_ptr]);
      model_ptr = model_ptr + 8'd1;
    end
    bus_stop();
    wait_n(4);
    check("R6 counter one past last read", rd_addr, model_ptr);
  endtask

  initial begin
    bit ack;
    logic [7:0] keep;
    for (int i = 0; i < 256; i++) begin
      store[i] = 8'(i) ^ 8'h5A;
      model_mem[i] = 8'(i) ^ 8'h5A;
    end
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    check("R10 sda_oe after reset", sda_oe, 0);
    check("R10 wr_req after reset", wr_req, 0);
    check("R10 stop_evt after reset", stop_evt, 0);
    check("R10 counter after reset", rd_addr, 0);

    do_write(8'h10, 1, 8'hA5);
    do_write(8'h1E, 3, 8'h30);          // R4 page wrap: 1E, 1F, 10
    do_read(1'b1, 8'h10, 3);            // R7 random then R5 sequential
    do_read(1'b0, 8'h00, 2);            // R6 current-address read
    do_read(1'b1, 8'hFE, 3);            // R6 wrap FE, FF, 00
    do_read(1'b0, 8'h00, 1);            // R6 continues at 01

    // R9: strap mismatch, then bytes that would be address and data
    keep = rd_addr;
    bus_start();
    tx_byte({4'b1010, 3'b001, 1'b0}, ack); check("R9 no ACK on strap mismatch", ack, 0);
    tx_byte(8'h00, ack); check("R9 ignored byte not acknowledged", ack, 0);
    tx_byte(8'h77, ack); check("R9 ignored byte not acknowledged", ack, 0);
    bus_stop();
    bus_start();
    tx_byte({4'b0110, STRAP, 1'b0}, ack); check("R9 no ACK on prefix mismatch", ack, 0);
    tx_byte(8'h40, ack); check("R9 ignored byte not acknowledged", ack, 0);
    bus_stop();
    wait_n(4);
    check("R9 counter unchanged after mismatch", rd_addr, keep);

    // R8: busy suppresses device ACK, release restores it
    busy = 1'b1;
    bus_start();
    tx_byte(DEV_R, ack); check("R8 no device ACK while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    tx_byte(DEV_R, ack); check("R8 device ACK after busy clears", ack, 1);
    begin
      logic [7:0] d;
      rx_byte(1'b0, d);
      check("R6 read after polling", d, model_mem[model_ptr]);
      model_ptr = model_ptr + 8'd1;
    end
    bus_stop();
    wait_n(4);
    check("R6 counter after polling read", rd_addr, model_ptr);
    check("R1 one stop event per STOP", stops_seen, stops_exp);
    check("R4 no stray write requests", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule